// File: doc/BRIEF.md
# Software-Tagged Three-Level Operand Store

This block holds the operands of one execution lane in three storage levels of different size. The large context level keeps every register of every resident warp. A small operand level keeps a few entries for each active-warp slot. A single-entry result level keeps one value per active-warp slot. Each source and destination operand arrives from the issue stage with a 2-bit level code chosen by software. The block does no tag matching, does no replacement, and never copies a value between levels on its own.

In each cycle the issue stage presents one thread context, given as a warp number and the active slot that warp occupies. With it come up to three source reads and one destination write. Every read returns its data through a registered port one cycle later, whatever level it named. A read of an operand-level or result-level entry that has not been written since its slot was last cleared is flagged as an error. So is any access that uses the reserved level code. A slot-clear input empties both upper levels of one slot when its warp leaves the active set. The context level keeps its contents across such a clear.

Top module: `opnd_hier`

## Requirements
- R1: After reset, every read-valid, read-error, read-data and write-error output is 0, and every operand-level and result-level entry is empty.
- R2: Level code 00 selects the context level. It is addressed by `iss_warp` and the full index field, it always reads without error, and it returns the last value written there.
- R3: Level code 01 selects the operand level. It has ORFN entries per slot, addressed by `iss_slot` and the low log2(ORFN) bits of the index field, and the higher index bits are ignored. Each entry is independent of all the others.
- R4: Level code 10 selects the result level, which has exactly one entry per slot and ignores the index field. A later write replaces an earlier one.
- R5: A read request on port p yields `rd_vld[p]` = 1 together with its data in the following cycle for every level code, and `rd_vld[p]` = 0 in that cycle when no request was made.
- R6: A write changes only the entry of the level it names. The same index in the other levels keeps its value and its empty or filled state.
- R7: Reading an operand-level or result-level entry that is empty gives `rd_err` = 1 and `rd_data` = 0. Whenever `rd_err` is 1, `rd_data` is 0.
- R8: Level code 11 is reserved. A read that uses it returns `rd_err` = 1 the next cycle. A write that uses it stores nothing and sets `wr_err` = 1 the next cycle. `wr_err` is 0 after any other cycle.
- R9: A pulse on `deact_en` empties every operand-level and result-level entry of `deact_slot`. Other slots and the context level are untouched.
- R10: The three read ports work independently in the same cycle, each with its own level and index.
- R11: A read in the same cycle as a write to the same entry returns the value held before that write. When a write and a clear target the same slot in the same cycle, the clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_slot | input | SW | Active slot of the issuing thread context |
| iss_warp | input | WW | Warp number of the issuing thread context |
| rd_en | input | NRD | Read request per port |
| rd_lvl | input | NRD x 2 | Level code per read port |
| rd_idx | input | NRD x IW | Register index per read port |
| wr_en | input | 1 | Write request |
| wr_lvl | input | 2 | Level code of the write |
| wr_idx | input | IW | Register index of the write |
| wr_data | input | DW | Write data |
| deact_en | input | 1 | Clear the upper levels of one slot |
| deact_slot | input | SW | Slot to clear |
| rd_vld | output | NRD | Read data valid, one cycle after request |
| rd_err | output | NRD | Read of empty entry or reserved level |
| rd_data | output | NRD x DW | Read data |
| wr_err | output | 1 | Previous write used the reserved level |

## Verification
Every context-level location is written and then read back on all three ports at once, each port with a different index. This shows whether the warp and index address bits are decoded correctly and whether the ports are independent. Every operand-level entry of every slot is filled with index values whose high bits are set. Those entries are then read next to the context and result levels at matching indices, which separates correct level routing from writes that spill into other levels or from a wrong index truncation. The remaining patterns are reserved-code accesses, a clear of one slot among several filled ones, and same-cycle read/write and write/clear pairs. Each one isolates the error paths, the per-slot reach of a clear, and the update order inside a single cycle.

// File: rtl/ohr_pkg.sv
package ohr_pkg;
   typedef enum logic [1:0] {
      LV_CTX = 2'b00,
      LV_OPN = 2'b01,
      LV_RES = 2'b10,
      LV_RSV = 2'b11
   } lvl_e;
endpackage

// File: rtl/ohr_store.sv
module ohr_store #(
   parameter int DEPTH = 16,
   parameter int AW    = 4,
   parameter int SW    = 2,
   parameter int DW    = 32,
   parameter int NRD   = 3,
   parameter int GRP   = 4,
   parameter bit TRACK = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      we,
   input  logic [AW-1:0]             waddr,
   input  logic [DW-1:0]             wdata,
   input  logic                      clr_en,
   input  logic [SW-1:0]             clr_grp,
   input  logic [NRD-1:0][AW-1:0]    raddr,
   output logic [NRD-1:0][DW-1:0]    rdata,
   output logic [NRD-1:0]            rhit
);
   if (DEPTH != (1 << AW)) begin : g_bad_depth
      $error("ohr_store: DEPTH must equal 2**AW");
   end
   if (GRP < 1 || (DEPTH % GRP) != 0) begin : g_bad_grp
      $error("ohr_store: GRP must divide DEPTH");
   end

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int e = 0; e < DEPTH; e++) mem[e] <= '0;
      end else if (we) begin
         mem[waddr] <= wdata;
      end
   end

   for (genvar p = 0; p < NRD; p++) begin : g_rd
      assign rdata[p] = mem[raddr[p]];
   end

   if (TRACK) begin : g_track
      logic [DEPTH-1:0] full;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            full <= '0;
         end else begin
            for (int e = 0; e < DEPTH; e++) begin
               if (clr_en && (int'(clr_grp) == e / GRP))
                  full[e] <= 1'b0;
               else if (we && (int'(waddr) == e))
                  full[e] <= 1'b1;
            end
         end
      end
      for (genvar p = 0; p < NRD; p++) begin : g_hit
         assign rhit[p] = full[raddr[p]];
      end
   end else begin : g_plain
      logic unused_clr;
      assign unused_clr = ^{clr_en, clr_grp};
      assign rhit = '1;
   end
endmodule

// File: rtl/ohr_rdport.sv
module ohr_rdport
   import ohr_pkg::*;
#(
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic [1:0]    lvl,
   input  logic [DW-1:0] ctx_d,
   input  logic [DW-1:0] opn_d,
   input  logic          opn_hit,
   input  logic [DW-1:0] res_d,
   input  logic          res_hit,
   output logic          vld,
   output logic          err,
   output logic [DW-1:0] data
);
   logic          err_n;
   logic [DW-1:0] data_n;

   always_comb begin
      err_n  = 1'b0;
      data_n = '0;
      case (lvl_e'(lvl))
         LV_CTX: data_n = ctx_d;
         LV_OPN: begin
            err_n  = !opn_hit;
            data_n = opn_hit ? opn_d : '0;
         end
         LV_RES: begin
            err_n  = !res_hit;
            data_n = res_hit ? res_d : '0;
         end
         default: err_n = 1'b1;
      endcase
      if (!en) begin
         err_n  = 1'b0;
         data_n = '0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld  <= 1'b0;
         err  <= 1'b0;
         data <= '0;
      end else begin
         vld  <= en;
         err  <= err_n;
         data <= data_n;
      end
   end
endmodule

// File: rtl/opnd_hier.sv
module opnd_hier
   import ohr_pkg::*;
#(
   parameter int NSLOT = 4,
   parameter int NWARP = 4,
   parameter int MREG  = 8,
   parameter int ORFN  = 4,
   parameter int DW    = 16,
   parameter int NRD   = 3,
   parameter int SW    = $clog2(NSLOT),
   parameter int WW    = $clog2(NWARP),
   parameter int IW    = $clog2(MREG)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [SW-1:0]             iss_slot,
   input  logic [WW-1:0]             iss_warp,
   input  logic [NRD-1:0]            rd_en,
   input  logic [NRD-1:0][1:0]       rd_lvl,
   input  logic [NRD-1:0][IW-1:0]    rd_idx,
   input  logic                      wr_en,
   input  logic [1:0]                wr_lvl,
   input  logic [IW-1:0]             wr_idx,
   input  logic [DW-1:0]             wr_data,
   input  logic                      deact_en,
   input  logic [SW-1:0]             deact_slot,
   output logic [NRD-1:0]            rd_vld,
   output logic [NRD-1:0]            rd_err,
   output logic [NRD-1:0][DW-1:0]    rd_data,
   output logic                      wr_err
);
   localparam int OIW    = $clog2(ORFN);
   localparam int CAW    = WW + IW;
   localparam int OAW    = SW + OIW;
   localparam int C_DEP  = NWARP * MREG;
   localparam int O_DEP  = NSLOT * ORFN;

   if (NSLOT < 2 || (1 << SW) != NSLOT) begin : g_bad_slot
      $error("opnd_hier: NSLOT must be a power of two of at least 2");
   end
   if (NWARP < 2 || (1 << WW) != NWARP) begin : g_bad_warp
      $error("opnd_hier: NWARP must be a power of two of at least 2");
   end
   if (MREG < 2 || (1 << IW) != MREG) begin : g_bad_mreg
      $error("opnd_hier: MREG must be a power of two of at least 2");
   end
   if (ORFN < 2 || (1 << OIW) != ORFN || ORFN > MREG) begin : g_bad_orfn
      $error("opnd_hier: ORFN must be a power of two in 2..MREG");
   end
   if (NRD < 1) begin : g_bad_nrd
      $error("opnd_hier: NRD must be at least 1");
   end

   logic c_we, o_we, r_we;
   assign c_we = wr_en && (lvl_e'(wr_lvl) == LV_CTX);
   assign o_we = wr_en && (lvl_e'(wr_lvl) == LV_OPN);
   assign r_we = wr_en && (lvl_e'(wr_lvl) == LV_RES);

   logic [NRD-1:0][CAW-1:0] c_ra;
   logic [NRD-1:0][OAW-1:0] o_ra;
   logic [NRD-1:0][SW-1:0]  r_ra;
   for (genvar p = 0; p < NRD; p++) begin : g_addr
      assign c_ra[p] = {iss_warp, rd_idx[p]};
      assign o_ra[p] = {iss_slot, rd_idx[p][OIW-1:0]};
      assign r_ra[p] = iss_slot;
   end

   logic [NRD-1:0][DW-1:0] c_rd, o_rd, r_rd;
   logic [NRD-1:0]         unused_chit, o_hit, r_hit;

   ohr_store #(.DEPTH(C_DEP), .AW(CAW), .SW(SW), .DW(DW), .NRD(NRD),
               .GRP(MREG), .TRACK(1'b0)) u_ctx (
      .clk(clk), .rst_n(rst_n), .we(c_we), .waddr({iss_warp, wr_idx}),
      .wdata(wr_data), .clr_en(1'b0), .clr_grp(deact_slot),
      .raddr(c_ra), .rdata(c_rd), .rhit(unused_chit));

   ohr_store #(.DEPTH(O_DEP), .AW(OAW), .SW(SW), .DW(DW), .NRD(NRD),
               .GRP(ORFN), .TRACK(1'b1)) u_opn (
      .clk(clk), .rst_n(rst_n), .we(o_we),
      .waddr({iss_slot, wr_idx[OIW-1:0]}), .wdata(wr_data),
      .clr_en(deact_en), .clr_grp(deact_slot),
      .raddr(o_ra), .rdata(o_rd), .rhit(o_hit));

   ohr_store #(.DEPTH(NSLOT), .AW(SW), .SW(SW), .DW(DW), .NRD(NRD),
               .GRP(1), .TRACK(1'b1)) u_res (
      .clk(clk), .rst_n(rst_n), .we(r_we), .waddr(iss_slot),
      .wdata(wr_data), .clr_en(deact_en), .clr_grp(deact_slot),
      .raddr(r_ra), .rdata(r_rd), .rhit(r_hit));

   for (genvar p = 0; p < NRD; p++) begin : g_port
      ohr_rdport #(.DW(DW)) u_port (
         .clk(clk), .rst_n(rst_n), .en(rd_en[p]), .lvl(rd_lvl[p]),
         .ctx_d(c_rd[p]), .opn_d(o_rd[p]), .opn_hit(o_hit[p]),
         .res_d(r_rd[p]), .res_hit(r_hit[p]),
         .vld(rd_vld[p]), .err(rd_err[p]), .data(rd_data[p]));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wr_err <= 1'b0;
      else        wr_err <= wr_en && (lvl_e'(wr_lvl) == LV_RSV);
   end
endmodule

// File: rtl/ohr_chk.sv
module ohr_chk #(
   parameter int NRD = 3,
   parameter int DW  = 16
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic [NRD-1:0]         rd_en,
   input logic [NRD-1:0][1:0]    rd_lvl,
   input logic [NRD-1:0]         rd_vld,
   input logic [NRD-1:0]         rd_err,
   input logic [NRD-1:0][DW-1:0] rd_data,
   input logic                   wr_en,
   input logic [1:0]             wr_lvl,
   input logic                   wr_err
);
   for (genvar p = 0; p < NRD; p++) begin : g_p
      a_r5_vld_follows: assert property (@(posedge clk) disable iff (!rst_n)
         rd_en[p] |=> rd_vld[p]);
      a_r5_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
         !rd_en[p] |=> !rd_vld[p]);
      a_r8_rsv_read: assert property (@(posedge clk) disable iff (!rst_n)
         (rd_en[p] && rd_lvl[p] == 2'b11) |=> rd_err[p]);
      a_r2_ctx_no_err: assert property (@(posedge clk) disable iff (!rst_n)
         (rd_en[p] && rd_lvl[p] == 2'b00) |=> !rd_err[p]);
      a_r7_err_zero: assert property (@(posedge clk) disable iff (!rst_n)
         rd_err[p] |-> (rd_data[p] == '0));
   end

   a_r8_wr_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_lvl == 2'b11) |=> wr_err);
   a_r8_wr_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && wr_lvl == 2'b11) |=> !wr_err);
endmodule

bind opnd_hier ohr_chk #(.NRD(NRD), .DW(DW)) u_chk (
   .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_lvl(rd_lvl),
   .rd_vld(rd_vld), .rd_err(rd_err), .rd_data(rd_data),
   .wr_en(wr_en), .wr_lvl(wr_lvl), .wr_err(wr_err));

// File: tb/opnd_hier_test.sv
module opnd_hier_test;
   localparam int NSLOT = 4, NWARP = 4, MREG = 8, ORFN = 4, DW = 16, NRD = 3;
   localparam int SW = 2, WW = 2, IW = 3;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic                     rst_n;
   logic [SW-1:0]            iss_slot;
   logic [WW-1:0]            iss_warp;
   logic [NRD-1:0]           rd_en;
   logic [NRD-1:0][1:0]      rd_lvl;
   logic [NRD-1:0][IW-1:0]   rd_idx;
   logic                     wr_en;
   logic [1:0]               wr_lvl;
   logic [IW-1:0]            wr_idx;
   logic [DW-1:0]            wr_data;
   logic                     deact_en;
   logic [SW-1:0]            deact_slot;
   logic [NRD-1:0]           rd_vld, rd_err;
   logic [NRD-1:0][DW-1:0]   rd_data;
   logic                     wr_err;

   opnd_hier #(.NSLOT(NSLOT), .NWARP(NWARP), .MREG(MREG), .ORFN(ORFN),
               .DW(DW), .NRD(NRD)) uut (.*);

   int total = 0, bad = 0;

   logic [DW-1:0] m_ctx [NWARP][MREG];
   logic [DW-1:0] m_opn [NSLOT][ORFN];
   logic [DW-1:0] m_res [NSLOT];
   bit            m_ov  [NSLOT][ORFN];
   bit            m_rv  [NSLOT];

   function automatic logic [DW-1:0] pat(input int a, input int b);
      return DW'(a * 73 + b * 11 + 5);
   endfunction

   function automatic void model_read(input bit [1:0] l, input int s, input int w,
                                      input int i, output bit e, output logic [DW-1:0] d);
      e = 1'b0; d = '0;
      case (l)
         2'd0: d = m_ctx[w][i];
         2'd1: if (m_ov[s][i % ORFN]) d = m_opn[s][i % ORFN]; else e = 1'b1;
         2'd2: if (m_rv[s]) d = m_res[s]; else e = 1'b1;
         default: e = 1'b1;
      endcase
   endfunction

   task automatic check(input string tag, input string what, input logic [DW-1:0] act,
                        input logic [DW-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic cyc(input string tag, input int slot, input int warp, input bit [2:0] re,
                      input bit [2:0][1:0] rl, input int i0, input int i1, input int i2,
                      input bit we, input bit [1:0] wl, input int wi,
                      input logic [DW-1:0] wd, input bit dn, input int ds);
      bit            ee [NRD];
      logic [DW-1:0] ed [NRD];
      int            ix [NRD];
      ix[0] = i0; ix[1] = i1; ix[2] = i2;
      @(negedge clk);
      iss_slot = SW'(slot); iss_warp = WW'(warp);
      rd_en = re; rd_lvl = rl;
      for (int p = 0; p < NRD; p++) rd_idx[p] = IW'(ix[p]);
      wr_en = we; wr_lvl = wl; wr_idx = IW'(wi); wr_data = wd;
      deact_en = dn; deact_slot = SW'(ds);
      for (int p = 0; p < NRD; p++) begin
         if (re[p]) model_read(rl[p], slot, warp, ix[p], ee[p], ed[p]);
         else begin ee[p] = 1'b0; ed[p] = '0; end
      end
      @(posedge clk);
      #1;
      for (int p = 0; p < NRD; p++) begin
         check(tag, $sformatf("port%0d vld", p), DW'(rd_vld[p]), DW'(re[p]));
         if (re[p]) begin
            check(tag, $sformatf("port%0d err", p), DW'(rd_err[p]), DW'(ee[p]));
            check(tag, $sformatf("port%0d data", p), rd_data[p], ed[p]);
         end
      end
      check(tag, "wr_err", DW'(wr_err), DW'(we && wl == 2'd3));
      if (we) begin
         case (wl)
            2'd0: m_ctx[warp][wi] = wd;
            2'd1: begin m_opn[slot][wi % ORFN] = wd; m_ov[slot][wi % ORFN] = 1'b1; end
            2'd2: begin m_res[slot] = wd; m_rv[slot] = 1'b1; end
            default: ;
         endcase
      end
      if (dn) begin
         for (int k = 0; k < ORFN; k++) m_ov[ds][k] = 1'b0;
         m_rv[ds] = 1'b0;
      end
   endtask

   task automatic wr1(input string tag, input int s, input int w, input bit [1:0] l,
                      input int i, input logic [DW-1:0] d);
      cyc(tag, s, w, 3'b000, 6'd0, 0, 0, 0, 1'b1, l, i, d, 1'b0, 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      for (int w = 0; w < NWARP; w++) for (int r = 0; r < MREG; r++) m_ctx[w][r] = '0;
      for (int s = 0; s < NSLOT; s++) begin
         m_res[s] = '0; m_rv[s] = 1'b0;
         for (int k = 0; k < ORFN; k++) begin m_opn[s][k] = '0; m_ov[s][k] = 1'b0; end
      end
      rst_n = 1'b0; iss_slot = '0; iss_warp = '0; rd_en = '0; rd_lvl = '0; rd_idx = '0;
      wr_en = 1'b0; wr_lvl = '0; wr_idx = '0; wr_data = '0; deact_en = 1'b0; deact_slot = '0;
      repeat (2) @(posedge clk);
      #1;
      // R1: reset state of all outputs
      check("R1", "rd_vld", DW'(rd_vld), '0);
      check("R1", "rd_err", DW'(rd_err), '0);
      check("R1", "rd_data", rd_data[0] | rd_data[1] | rd_data[2], '0);
      check("R1", "wr_err", DW'(wr_err), '0);
      @(negedge clk);
      rst_n = 1'b1;

      // R1 and R7: every upper-level entry is empty after reset
      for (int s = 0; s < NSLOT; s++)
         for (int i = 0; i < ORFN; i++)
            cyc("R7", s, 0, 3'b011, {2'd0, 2'd2, 2'd1}, i, 0, 0, 1'b0, 2'd0, 0, '0, 1'b0, 0);

      // R2: fill the whole context level
      for (int w = 0; w < NWARP; w++)
         for (int r = 0; r < MREG; r++)
            wr1("R2", w % NSLOT, w, 2'd0, r, pat(w, r));
      // R10: three ports, three indices, same cycle
      for (int w = 0; w < NWARP; w++)
         for (int r = 0; r < MREG; r++)
            cyc("R10", 0, w, 3'b111, {2'd0, 2'd0, 2'd0}, r, (r + 1) % MREG, (r + 3) % MREG,
                1'b0, 2'd0, 0, '0, 1'b0, 0);

      // R3: fill every operand entry using indices with high bits set
      for (int s = 0; s < NSLOT; s++)
         for (int i = 0; i < ORFN; i++)
            wr1("R3", s, 0, 2'd1, i + ORFN * (i & 1), pat(s + 9, i) ^ 16'h4000);
      for (int s = 0; s < NSLOT; s++)
         for (int i = 0; i < ORFN; i++)
            cyc("R3", s, 0, 3'b111, {2'd1, 2'd1, 2'd1}, i, i + ORFN, (i + 2) % MREG,
                1'b0, 2'd0, 0, '0, 1'b0, 0);

      // R6: operand writes left context level and result level alone
      for (int s = 0; s < NSLOT; s++)
         for (int i = 0; i < MREG; i++)
            cyc("R6", s, s, 3'b111, {2'd2, 2'd0, 2'd1}, i, i, 0,
                1'b0, 2'd0, 0, '0, 1'b0, 0);

      // R4: one result entry per slot, later write replaces earlier
      for (int s = 0; s < NSLOT; s++) begin
         wr1("R4", s, 0, 2'd2, 1, pat(s, 40));
         wr1("R4", s, 0, 2'd2, 6, pat(s, 50) ^ 16'h8000);
      end
      for (int s = 0; s < NSLOT; s++)
         cyc("R4", s, 0, 3'b111, {2'd2, 2'd2, 2'd2}, 0, 3, 7, 1'b0, 2'd0, 0, '0, 1'b0, 0);

      // R5: mixed levels across ports, every level returns in the same cycle
      for (int s = 0; s < NSLOT; s++)
         cyc("R5", s, (s + 1) % NWARP, 3'b111, {2'd2, 2'd1, 2'd0}, s, s + 1, s,
             1'b0, 2'd0, 0, '0, 1'b0, 0);
      cyc("R5", 1, 1, 3'b010, {2'd0, 2'd1, 2'd0}, 0, 2, 0, 1'b0, 2'd0, 0, '0, 1'b0, 0);

      // R8: reserved reads and a reserved write that stores nothing
      cyc("R8", 0, 0, 3'b101, {2'd3, 2'd0, 2'd3}, 1, 0, 2, 1'b0, 2'd0, 0, '0, 1'b0, 0);
      cyc("R8", 2, 2, 3'b000, 6'd0, 0, 0, 0, 1'b1, 2'd3, 1, 16'hdead, 1'b0, 0);
      cyc("R8", 2, 2, 3'b111, {2'd2, 2'd1, 2'd0}, 1, 1, 0, 1'b0, 2'd0, 0, '0, 1'b0, 0);

      // R9: clear slot 1 only
      cyc("R9", 0, 0, 3'b000, 6'd0, 0, 0, 0, 1'b0, 2'd0, 0, '0, 1'b1, 1);
      for (int s = 0; s < NSLOT; s++)
         for (int i = 0; i < ORFN; i++)
            cyc("R9", s, s, 3'b111, {2'd0, 2'd2, 2'd1}, i, 0, i + 4,
                1'b0, 2'd0, 0, '0, 1'b0, 0);

      // R11: read during write sees old value, then new value
      cyc("R11", 0, 0, 3'b011, {2'd0, 2'd2, 2'd1}, 2, 0, 0,
          1'b1, 2'd1, 2, 16'h1234, 1'b0, 0);
      cyc("R11", 0, 0, 3'b001, {2'd0, 2'd0, 2'd1}, 2, 0, 0, 1'b0, 2'd0, 0, '0, 1'b0, 0);
      cyc("R11", 3, 3, 3'b001, {2'd0, 2'd0, 2'd0}, 5, 0, 0,
          1'b1, 2'd0, 5, 16'h5a5a, 1'b0, 0);
      cyc("R11", 3, 3, 3'b001, {2'd0, 2'd0, 2'd0}, 5, 0, 0, 1'b0, 2'd0, 0, '0, 1'b0, 0);
      // R11: write and clear on the same slot, clear wins
      cyc("R11", 2, 0, 3'b000, 6'd0, 0, 0, 0, 1'b1, 2'd2, 0, 16'hbeef, 1'b1, 2);
      cyc("R11", 2, 0, 3'b011, {2'd0, 2'd1, 2'd2}, 0, 3, 0, 1'b0, 2'd0, 0, '0, 1'b0, 0);
      // write to another slot while slot 2 is cleared survives
      cyc("R9", 3, 0, 3'b000, 6'd0, 0, 0, 0, 1'b1, 2'd1, 0, 16'h7777, 1'b1, 2);
      cyc("R9", 3, 0, 3'b011, {2'd0, 2'd2, 2'd1}, 0, 0, 0, 1'b0, 2'd0, 0, '0, 1'b0, 0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule